// File: doc/BRIEF.md
# NVM Word Read Register Controller

This block is the register front end through which a host fetches one 16-bit word from a non-volatile memory. The host writes a command word whose address field holds the byte address shifted left by one (so the word address lands at bit 2). That write starts an access. A sequencer then counts a configurable number of access cycles, latches the word from the memory model, and raises a read-valid flag in bit 0 of the same command register. The word itself appears in bits 31:16 of that register. The host polls bit 0 and then takes the data.

A second register, the status register, holds three sticky flags: correctable ECC error, uncorrectable ECC error, and access timeout. The host clears a flag by writing one to its bit. ECC outcomes are injected from the memory model side at the cycle the access completes. A test hook, `access_hold`, stops an access from ever completing so that the timeout counter can be exercised.

The sequencer has three states: `ST_IDLE`, `ST_BUSY` and `ST_VALID`. Its transitions are:
- `ST_IDLE` to `ST_BUSY` on a command write.
- `ST_BUSY` to `ST_BUSY` (restart) on a further command write.
- `ST_BUSY` to `ST_VALID` when the latency count is reached and the hold is low.
- `ST_BUSY` to `ST_IDLE` when the timeout count is reached.
- `ST_VALID` to `ST_BUSY` on a command write.

Top module: `nvm_word_reader`

## Requirements
- R1: After reset, the command register (host_sel=0) reads 0 and the status register (host_sel=1) reads 0.
- R2: A write with host_wr=1 and host_sel=0 starts a read of word address host_wdata[2+:WA_W]. Bit 0 of the command register reads 0 for the first ACC_LAT-1 clock edges after the write edge and reads 1 from the ACC_LAT-th edge on. At that point bits [2+:WA_W] echo the word address.
- R3: Once valid, bits 31:16 of the command register hold the model word, which is (A*40503 + 4660) mod 65536 for word address A.
- R4: While bit 0 reads 0, bits 31:16 read 0. Once set, valid and the data stay unchanged until the next command write.
- R5: A command write during an access restarts it. Valid then appears ACC_LAT edges after the last write, carrying the new address's word.
- R6: A command write while valid is set clears valid from the next cycle.
- R7: If ecc_corr_inj is high at the completing edge, status bit 0 (correctable) becomes 1 and stays set. Valid and data are delivered normally.
- R8: If ecc_uncorr_inj is high at the completing edge, status bit 1 (uncorrectable) becomes 1 and stays set.
- R9: Writing the status register with a 1 in bit 0, 1 or 2 clears that flag. Writing 0 to a bit leaves that flag unchanged.
- R10: With access_hold high, an access never completes. On the TMO_CYCLES-th edge after the command write, the access is abandoned: status bit 2 (timeout) becomes 1 and valid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_sel | input | 1 | Register select: 0 = command, 1 = status |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the selected register |
| access_hold | input | 1 | Test hook: blocks completion of the access |
| ecc_corr_inj | input | 1 | Correctable ECC outcome from the memory model |
| ecc_uncorr_inj | input | 1 | Uncorrectable ECC outcome from the memory model |

## Verification
Every word address of the default 8-bit configuration is read in turn. Each read is sampled one edge before and exactly at the expected completion, which separates an off-by-one in the latency from wrong data or a wrong address echo. Each new write of the sweep also shows that valid clears.

A restart in mid-access, reads with each ECC flag injected, and status writes with zero, foreign-bit and matching-bit masks tell a correct restart and write-one-to-clear behaviour apart from lost or over-eager clears. A held access is sampled one edge before and at the timeout edge, and is followed by a normal read to show recovery.

// File: rtl/nvm_rd_pkg.sv
package nvm_rd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUSY  = 2'd1,
        ST_VALID = 2'd2
    } seq_state_e;

    localparam int VALID_BIT   = 0;
    localparam int ADDR_LSB    = 2;
    localparam int DATA_LSB    = 16;
    localparam int WORD_W      = 16;
    localparam int ST_CORR_BIT = 0;
    localparam int ST_UNC_BIT  = 1;
    localparam int ST_TMO_BIT  = 2;
    localparam int FLAG_N      = 3;
endpackage

// File: rtl/nvm_mem_model.sv
module nvm_mem_model #(
    parameter int WA_W = 8
) (
    input  logic [WA_W-1:0] waddr,
    output logic [15:0]     word
);
    localparam logic [31:0] MUL = 32'd40503;
    localparam logic [31:0] OFS = 32'd4660;

    logic [31:0] prod;

    always_comb begin
        prod = 32'(waddr) * MUL + OFS;
        word = prod[15:0];
    end

    logic unused_prod_hi;
    assign unused_prod_hi = ^prod[31:16];
endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
    import nvm_rd_pkg::*;
#(
    parameter int ACC_LAT    = 4,
    parameter int TMO_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic hold,
    output logic valid,
    output logic done,
    output logic tmo_evt
);
    localparam int CW = $clog2(TMO_CYCLES + 1);
    localparam logic [CW-1:0] LAT_LAST = CW'(ACC_LAT - 1);
    localparam logic [CW-1:0] TMO_LAST = CW'(TMO_CYCLES - 1);

    seq_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        done    = 1'b0;
        tmo_evt = 1'b0;
        if (start) begin
            state_d = ST_BUSY;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_BUSY: begin
                    cnt_d = cnt_q + 1'b1;
                    if (!hold && cnt_q == LAT_LAST) begin
                        state_d = ST_VALID;
                        done    = 1'b1;
                    end else if (cnt_q == TMO_LAST) begin
                        state_d = ST_IDLE;
                        tmo_evt = 1'b1;
                    end
                end
                ST_VALID: state_d = ST_VALID;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    assign valid = (state_q == ST_VALID);
endmodule

// File: rtl/nvm_word_reader.sv
module nvm_word_reader
    import nvm_rd_pkg::*;
#(
    parameter int WA_W       = 8,
    parameter int ACC_LAT    = 4,
    parameter int TMO_CYCLES = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_sel,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    input  logic        access_hold,
    input  logic        ecc_corr_inj,
    input  logic        ecc_uncorr_inj
);
    localparam int ADDR_MSB = ADDR_LSB + WA_W - 1;

    logic              cmd_wr, stat_wr;
    logic [WA_W-1:0]   addr_q;
    logic [WORD_W-1:0] data_q, mem_word;
    logic [FLAG_N-1:0] flags_q, flag_set, flag_clr;
    logic              valid, done, tmo_evt;

    assign cmd_wr  = host_wr && !host_sel;
    assign stat_wr = host_wr &&  host_sel;

    nvm_seq #(.ACC_LAT(ACC_LAT), .TMO_CYCLES(TMO_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(cmd_wr), .hold(access_hold),
        .valid(valid), .done(done), .tmo_evt(tmo_evt)
    );

    nvm_mem_model #(.WA_W(WA_W)) u_mem (.waddr(addr_q), .word(mem_word));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (cmd_wr) addr_q <= host_wdata[ADDR_MSB:ADDR_LSB];
            if (done)   data_q <= mem_word;
        end
    end

    always_comb begin
        flag_set              = '0;
        flag_set[ST_CORR_BIT] = done && ecc_corr_inj;
        flag_set[ST_UNC_BIT]  = done && ecc_uncorr_inj;
        flag_set[ST_TMO_BIT]  = tmo_evt;
        flag_clr              = stat_wr ? host_wdata[FLAG_N-1:0] : '0;
    end

    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           flags_q[i] <= 1'b0;
            else if (flag_set[i]) flags_q[i] <= 1'b1;
            else if (flag_clr[i]) flags_q[i] <= 1'b0;
        end
    end

    always_comb begin
        host_rdata = '0;
        if (host_sel) begin
            host_rdata[FLAG_N-1:0] = flags_q;
        end else begin
            host_rdata[VALID_BIT]            = valid;
            host_rdata[ADDR_MSB:ADDR_LSB]    = addr_q;
            host_rdata[31:DATA_LSB]          = valid ? data_q : '0;
        end
    end

    logic unused_wbits;
    assign unused_wbits = ^host_wdata[31:ADDR_MSB+1];
endmodule

// File: rtl/nvm_word_reader_chk.sv
module nvm_word_reader_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr,
    input logic        host_sel,
    input logic [31:0] host_wdata,
    input logic        access_hold,
    input logic        valid,
    input logic [15:0] data_q,
    input logic [2:0]  flags_q
);
    p_wr_clears_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_sel) |=> !valid);

    p_valid_needs_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> !$past(access_hold));

    p_valid_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !(host_wr && !host_sel)) |=> (valid && $stable(data_q)));

    p_corr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[0] && !(host_wr && host_sel && host_wdata[0])) |=> flags_q[0]);

    p_unc_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[1] && !(host_wr && host_sel && host_wdata[1])) |=> flags_q[1]);

    p_tmo_no_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[2]) |-> !valid);
endmodule

bind nvm_word_reader nvm_word_reader_chk u_chk (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .access_hold(access_hold), .valid(valid),
    .data_q(data_q), .flags_q(flags_q)
);

// File: tb/sim_nvm_word_reader.sv
`timescale 1ns/1ps
module sim_nvm_word_reader;
    localparam int WA_W = 8;
    localparam int LAT  = 4;
    localparam int TMO  = 32;

    logic        clk = 0, rst_n = 0;
    logic        host_wr = 0, host_sel = 0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        access_hold = 0, ecc_corr_inj = 0, ecc_uncorr_inj = 0;

    int checks = 0, failures = 0;

    always #5 clk = ~clk;

    nvm_word_reader #(.WA_W(WA_W), .ACC_LAT(LAT), .TMO_CYCLES(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .access_hold(access_hold), .ecc_corr_inj(ecc_corr_inj),
        .ecc_uncorr_inj(ecc_uncorr_inj)
    );

    function automatic logic [15:0] model(input int a);
        int unsigned p;
        p = a * 40503 + 4660;
        return p[15:0];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic s, output logic [31:0] v);
        host_sel = s;
        #1;
        v = host_rdata;
        host_sel = 0;
    endtask

    task automatic wr(input logic s, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1; host_sel = s; host_wdata = d;
        @(negedge clk);
        host_wr = 0; host_sel = 0; host_wdata = '0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] cmd_of(input int a);
        return 32'(a) << 2;
    endfunction

    task automatic done_summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        done_summary();
    end

    initial begin
        logic [31:0] v;
        wait_n(2);
        rst_n = 1;
        wait_n(1);
        rd(0, v); chk("R1 cmd reset", v, 32'h0);
        rd(1, v); chk("R1 status reset", v, 32'h0);

        // R2 R3 R4 R6: sweep every word address
        for (int a = 0; a < (1 << WA_W); a++) begin
            wr(0, cmd_of(a));
            rd(0, v); chk("R6 valid cleared after write", v[0], 1'b0);
            wait_n(LAT - 1);
            rd(0, v); chk("R4 not valid before latency", {v[31:16], 15'h0, v[0]}, 32'h0);
            wait_n(1);
            rd(0, v); chk("R2 R3 valid word", v, {model(a), 16'h0} | cmd_of(a) | 32'h1);
        end

        // R4: valid persists
        wait_n(5);
        rd(0, v); chk("R4 valid held", v, {model(255), 16'h0} | cmd_of(255) | 32'h1);

        // R5: restart mid-access
        wr(0, cmd_of(17));
        wait_n(1);
        wr(0, cmd_of(200));
        wait_n(LAT - 1);
        rd(0, v); chk("R5 not yet valid after restart", v[0], 1'b0);
        wait_n(1);
        rd(0, v); chk("R5 restarted word", v, {model(200), 16'h0} | cmd_of(200) | 32'h1);

        // R7: correctable
        ecc_corr_inj = 1;
        wr(0, cmd_of(33));
        wait_n(LAT);
        ecc_corr_inj = 0;
        rd(0, v); chk("R7 data still usable", v, {model(33), 16'h0} | cmd_of(33) | 32'h1);
        rd(1, v); chk("R7 corr flag", v, 32'h1);
        wr(1, 32'h0);
        rd(1, v); chk("R9 zero write keeps", v, 32'h1);
        wr(1, 32'h2);
        rd(1, v); chk("R9 other-bit write keeps", v, 32'h1);
        wr(1, 32'h1);
        rd(1, v); chk("R9 one clears corr", v, 32'h0);

        // R8: uncorrectable
        ecc_uncorr_inj = 1;
        wr(0, cmd_of(90));
        wait_n(LAT);
        ecc_uncorr_inj = 0;
        rd(1, v); chk("R8 uncorr flag", v, 32'h2);
        wait_n(3);
        rd(1, v); chk("R8 uncorr sticky", v, 32'h2);
        wr(1, 32'h1);
        rd(1, v); chk("R9 corr-bit write keeps uncorr", v, 32'h2);
        wr(1, 32'h2);
        rd(1, v); chk("R9 one clears uncorr", v, 32'h0);

        // R10: timeout
        access_hold = 1;
        wr(0, cmd_of(5));
        wait_n(TMO - 1);
        rd(1, v); chk("R10 no timeout before limit", v, 32'h0);
        rd(0, v); chk("R10 not valid while held", v[0], 1'b0);
        wait_n(1);
        rd(1, v); chk("R10 timeout flag", v, 32'h4);
        rd(0, v); chk("R10 valid stays low", v[0], 1'b0);
        wait_n(4);
        rd(0, v); chk("R10 abandoned access stays invalid", v[0], 1'b0);
        access_hold = 0;
        wr(1, 32'h4);
        rd(1, v); chk("R9 one clears timeout", v, 32'h0);
        wr(0, cmd_of(6));
        wait_n(LAT);
        rd(0, v); chk("R10 recovery read", v, {model(6), 16'h0} | cmd_of(6) | 32'h1);

        done_summary();
    end
endmodule